// File: doc/BRIEF.md
# Chiplet Control Register File

This block is a bank of 64-bit registers for one partition of a chip. Agents on a simple register bus reach it with a request, a write enable, a word index, byte enables and 64-bit write data. Every request is acknowledged on the next clock. A read returns its data with that acknowledge.

The bank holds eight "aliased" registers: six control registers and two configuration registers. Each one can be reached through three indices. The first overwrites the register. The second ORs the write data into it. The third clears every bit that is set in the write data. Two independent agents can therefore flip their own bits without a read-modify-write race.

Four further registers take plain reads and writes: status, mask, protect-mode and atomic-lock. The set and clear indices are write-only. A read of one of them, an access to any unused index, or a partial-width access leaves all state alone, reads back as all-ones, and raises a one-cycle error flag.

Top module: `chiplet_ctrl_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to zero and `ack` and `err` go low. After reset, a read of any register returns zero.
- R2: Each cycle with `req` high is followed in the next cycle by `ack` high for exactly that cycle. `rdata` and `err` belong to that `ack` cycle. There is no `ack` without a preceding `req`.
- R3: A full-width write to a direct index replaces the register value, and a read of that index returns it. Control register i (0..5) sits at index 0x00+i. Configuration registers 0 and 1 sit at 0x08 and 0x09.
- R4: A full-width write to the set index ORs the write data into the register. For control register i the set index is 0x10+i. For configuration registers 0 and 1 it is 0x18 and 0x19.
- R5: A full-width write to the clear index clears the bits that are set in the write data. For control register i the clear index is 0x20+i. For configuration registers 0 and 1 it is 0x28 and 0x29.
- R6: Four registers take plain reads and overwrites: status at index 0x100, mask at 0x101, protect-mode at 0x3FE and atomic-lock at 0x3FF.
- R7: A read of any set or clear index returns all-ones, changes no register and raises `err`.
- R8: Any index of the 0x400-entry window that R3 to R6 do not name is unmapped. Examples are 0x06, 0x07, 0x16, 0x1A and 0x3FD. A read there returns all-ones, a write there is ignored, and both raise `err`.
- R9: An access whose byte enables `be` are not all ones is rejected. It changes no register, a read returns all-ones, and `err` is raised.
- R10: `err` is high only in an `ack` cycle. For a full-width access to a readable index, or a full-width write to any mapped index, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (10) | Word index (byte address >> 3) |
| be | input | DATA_W/8 (8) | Byte enables, all ones required |
| wdata | input | DATA_W (64) | Write data |
| rdata | output | DATA_W (64) | Read data, valid with `ack` |
| ack | output | 1 | Access acknowledge, one cycle after `req` |
| err | output | 1 | Error pulse for rejected or write-only/unmapped access |

## Verification
The bench uses the default parameters: six control registers, two configuration registers and a 10-bit word index. With these values the whole 0x400-entry window is small enough to sweep. After every register has been loaded with a distinct pattern, the bench reads each of the 1024 indices and compares the data and the error flag with its own map. This reaches the gaps between alias groups, such as 0x06, 0x16 and 0x26, and the indices next to the plain registers. Directed tasks cover the set and clear arithmetic on overlapping bit patterns, partial byte enables, and reset in the middle of a run.

// File: rtl/ccrf_pkg.sv
// Package: shared constants and helpers for the chiplet control register file.
// Assumes: the aliased registers are control registers first, then configuration registers.
package ccrf_pkg;

    // Direct index of aliased register k, given the two group bases.
    function automatic int unsigned alias_base(input int unsigned k,
                                               input int unsigned n_ctrl,
                                               input int unsigned ctrl_base,
                                               input int unsigned cfg_base);
        alias_base = (k < n_ctrl) ? (ctrl_base + k) : (cfg_base + (k - n_ctrl));
    endfunction

    // Roles of the plain registers, in the order of the plain register array.
    typedef enum int unsigned {
        PL_STATUS  = 0,
        PL_MASK    = 1,
        PL_PROTECT = 2,
        PL_LOCK    = 3
    } plain_role_e;

    localparam int unsigned NUM_PLAIN = 4;

endpackage

// File: rtl/ccrf_decode.sv
// Module: ccrf_decode
// Turns a word index into one-hot hit vectors for the direct, set and clear
// indices of the aliased registers and for the plain registers.
// Assumes: all configured indices are distinct and fit within ADDR_W bits.
module ccrf_decode #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_CTRL  = 6,
    parameter int unsigned NUM_CFG   = 2,
    parameter int unsigned CTRL_BASE = 'h000,
    parameter int unsigned CFG_BASE  = 'h008,
    parameter int unsigned SET_OFS   = 'h010,
    parameter int unsigned CLR_OFS   = 'h020,
    parameter int unsigned STAT_IDX  = 'h100,
    parameter int unsigned MASK_IDX  = 'h101,
    parameter int unsigned PROT_IDX  = 'h3FE,
    parameter int unsigned LOCK_IDX  = 'h3FF,
    localparam int unsigned NUM_ALIAS = NUM_CTRL + NUM_CFG
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    output logic [NUM_ALIAS-1:0]          hit_dir,
    output logic [NUM_ALIAS-1:0]          hit_set,
    output logic [NUM_ALIAS-1:0]          hit_clr,
    output logic [ccrf_pkg::NUM_PLAIN-1:0] hit_plain
);
    import ccrf_pkg::*;

    localparam int unsigned PLAIN_IDX [NUM_PLAIN] = '{STAT_IDX, MASK_IDX, PROT_IDX, LOCK_IDX};

    // One comparator triple per aliased register.
    for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
        localparam int unsigned BASE = alias_base(k, NUM_CTRL, CTRL_BASE, CFG_BASE);
        localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(BASE);
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE + SET_OFS);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE + CLR_OFS);
        assign hit_dir[k] = (addr == DIR_A);
        assign hit_set[k] = (addr == SET_A);
        assign hit_clr[k] = (addr == CLR_A);
    end

    // One comparator per plain register.
    for (genvar j = 0; j < NUM_PLAIN; j++) begin : g_plain
        localparam logic [ADDR_W-1:0] P_A = ADDR_W'(PLAIN_IDX[j]);
        assign hit_plain[j] = (addr == P_A);
    end

    // R3: any index selects at most one register view
    a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_dir, hit_set, hit_clr, hit_plain}));

endmodule

// File: rtl/ccrf_reg.sv
// Module: ccrf_reg
// One register with overwrite, OR-set and AND-clear update strobes.
// Assumes: at most one strobe is active per cycle. The caller qualifies the strobes.
module ccrf_reg #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Update the stored value on reset or on one of the three strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_en)  q <= wdata;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end

    // R4: after a set, every bit of the data is set
    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));
    // R5: after a clear, every bit of the data is cleared
    a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(wdata)) == '0));
    // R9: with no strobe the value holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || set_en || clr_en) |=> $stable(q));

endmodule

// File: rtl/chiplet_ctrl_regfile.sv
// Module: chiplet_ctrl_regfile
// Register file with aliased control and configuration registers and plain
// status, mask, protect-mode and atomic-lock registers. Each access is
// acknowledged one cycle after the request.
// Assumes: req lasts one cycle per access. Full-width accesses only.
module chiplet_ctrl_regfile #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_CTRL  = 6,
    parameter int unsigned NUM_CFG   = 2,
    parameter int unsigned CTRL_BASE = 'h000,
    parameter int unsigned CFG_BASE  = 'h008,
    parameter int unsigned SET_OFS   = 'h010,
    parameter int unsigned CLR_OFS   = 'h020,
    parameter int unsigned STAT_IDX  = 'h100,
    parameter int unsigned MASK_IDX  = 'h101,
    parameter int unsigned PROT_IDX  = 'h3FE,
    parameter int unsigned LOCK_IDX  = 'h3FF,
    localparam int unsigned BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err
);
    import ccrf_pkg::*;

    localparam int unsigned NUM_ALIAS = NUM_CTRL + NUM_CFG;

    logic [NUM_ALIAS-1:0] hit_dir, hit_set, hit_clr;
    logic [NUM_PLAIN-1:0] hit_plain;
    logic [DATA_W-1:0]    alias_q [NUM_ALIAS];
    logic [DATA_W-1:0]    plain_q [NUM_PLAIN];
    logic                 full_be, any_read_hit, any_alias_wo, bad, wr_ok;
    logic [DATA_W-1:0]    rd_mux;

    ccrf_decode #(
        .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .NUM_CFG(NUM_CFG),
        .CTRL_BASE(CTRL_BASE), .CFG_BASE(CFG_BASE),
        .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS),
        .STAT_IDX(STAT_IDX), .MASK_IDX(MASK_IDX),
        .PROT_IDX(PROT_IDX), .LOCK_IDX(LOCK_IDX)
    ) i_decode (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .hit_dir(hit_dir), .hit_set(hit_set), .hit_clr(hit_clr),
        .hit_plain(hit_plain)
    );

    // Classify the access: a rejected access never updates state.
    always_comb begin
        full_be      = &be;
        any_read_hit = |{hit_dir, hit_plain};
        any_alias_wo = |{hit_set, hit_clr};
        bad          = !full_be || !(any_read_hit || (any_alias_wo && we));
        wr_ok        = req && we && !bad;
    end

    // Aliased registers: control first, then configuration.
    for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias_reg
        ccrf_reg #(.DATA_W(DATA_W)) i_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_en (wr_ok && hit_dir[k]),
            .set_en(wr_ok && hit_set[k]),
            .clr_en(wr_ok && hit_clr[k]),
            .wdata(wdata), .q(alias_q[k])
        );
    end

    // Plain registers: overwrite only.
    for (genvar j = 0; j < NUM_PLAIN; j++) begin : g_plain_reg
        ccrf_reg #(.DATA_W(DATA_W)) i_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_en (wr_ok && hit_plain[j]),
            .set_en(1'b0),
            .clr_en(1'b0),
            .wdata(wdata), .q(plain_q[j])
        );
    end

    // Select read data from the single hit, all-ones if none.
    always_comb begin
        rd_mux = '1;
        for (int k = 0; k < NUM_ALIAS; k++)
            if (hit_dir[k]) rd_mux = alias_q[k];
        for (int j = 0; j < NUM_PLAIN; j++)
            if (hit_plain[j]) rd_mux = plain_q[j];
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '1;
        end else begin
            ack   <= req;
            err   <= req && bad;
            rdata <= (req && !we && !bad) ? rd_mux : '1;
        end
    end

    // R2: a request is acknowledged on the next cycle
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);
    // R2: no acknowledge without a request
    a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);
    // R10: the error flag only comes with an acknowledge
    a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);
    // R9: partial byte enables always raise the error flag
    a_r9_partial_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !(&be)) |=> err);
    // R7/R8: a failed read returns all-ones
    a_r8_bad_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> (!err || (rdata == '1)));

endmodule

// File: tb/test_chiplet_ctrl_regfile.sv
// Directed bench for chiplet_ctrl_regfile: one task per scenario.
module test_chiplet_ctrl_regfile;

    localparam int DW = 64;
    localparam int AW = 10;
    localparam logic [DW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    be = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ack, err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] r_data;
    logic          r_ack, r_err;

    // Expected contents: 8 aliased (index 0..7), 4 plain (status, mask, protect, lock).
    logic [DW-1:0] m_alias [8];
    logic [DW-1:0] m_plain [4];

    always #5 clk = ~clk;

    chiplet_ctrl_regfile i_chiplet_ctrl_regfile (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .rdata(rdata), .ack(ack), .err(err)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req_tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    // One bus access: drive at a falling edge, sample at the next falling edge.
    task automatic access(input logic w, input logic [AW-1:0] a,
                          input logic [7:0] b, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; be = b; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        r_data = rdata; r_ack = ack; r_err = err;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        foreach (m_alias[k]) m_alias[k] = '0;
        foreach (m_plain[j]) m_plain[j] = '0;
    endtask

    // Map a word index to (readable, value, write-legal) from the requirements.
    function automatic logic [DW-1:0] exp_read(input int idx, output logic e);
        e = 1'b0;
        if (idx <= 5)        return m_alias[idx];
        if (idx == 8)        return m_alias[6];
        if (idx == 9)        return m_alias[7];
        if (idx == 'h100)    return m_plain[0];
        if (idx == 'h101)    return m_plain[1];
        if (idx == 'h3FE)    return m_plain[2];
        if (idx == 'h3FF)    return m_plain[3];
        e = 1'b1;
        return ONES;
    endfunction

    function automatic int dir_idx(input int k);
        return (k < 6) ? k : 8 + (k - 6);
    endfunction

    task automatic t_reset_state();
        logic e;
        chk("R1 ack low in reset", {63'b0, ack}, 64'd0);
        for (int k = 0; k < 8; k++) begin
            access(1'b0, AW'(dir_idx(k)), 8'hFF, '0);
            chk("R1 aliased reg zero", r_data, 64'd0);
        end
        access(1'b0, 10'h3FF, 8'hFF, '0);
        chk("R1 lock reg zero", r_data, exp_read('h3FF, e));
        chk("R2 ack after req", {63'b0, r_ack}, 64'd1);
        chk("R10 no err on good read", {63'b0, r_err}, 64'd0);
        @(negedge clk);
        chk("R2 ack one cycle", {63'b0, ack}, 64'd0);
    endtask

    task automatic t_direct();
        for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] v = 64'hA5A5_0000_0000_0000 | (64'(k) << 8) | 64'(k * 3 + 1);
            access(1'b1, AW'(dir_idx(k)), 8'hFF, v);
            m_alias[k] = v;
            chk("R10 no err on direct write", {63'b0, r_err}, 64'd0);
            access(1'b0, AW'(dir_idx(k)), 8'hFF, '0);
            chk("R3 direct write readback", r_data, v);
        end
    endtask

    task automatic t_set_clear();
        for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] s = 64'hF0F0_0000_0000_FF00;
            logic [DW-1:0] c = 64'h00F0_A5A5_0000_0F01;
            access(1'b1, AW'(dir_idx(k) + 'h10), 8'hFF, s);
            m_alias[k] = m_alias[k] | s;
            chk("R10 no err on set write", {63'b0, r_err}, 64'd0);
            access(1'b0, AW'(dir_idx(k)), 8'hFF, '0);
            chk("R4 set alias ORs", r_data, m_alias[k]);
            access(1'b1, AW'(dir_idx(k) + 'h20), 8'hFF, c);
            m_alias[k] = m_alias[k] & ~c;
            access(1'b0, AW'(dir_idx(k)), 8'hFF, '0);
            chk("R5 clear alias clears", r_data, m_alias[k]);
        end
    endtask

    task automatic t_plain();
        int idx [4] = '{'h100, 'h101, 'h3FE, 'h3FF};
        for (int j = 0; j < 4; j++) begin
            logic [DW-1:0] v = 64'h1234_5678_9ABC_DEF0 ^ (64'(j) << 60);
            access(1'b1, AW'(idx[j]), 8'hFF, v);
            m_plain[j] = v;
            access(1'b0, AW'(idx[j]), 8'hFF, '0);
            chk("R6 plain reg readback", r_data, v);
        end
    endtask

    task automatic t_alias_read();
        access(1'b0, 10'h13, 8'hFF, '0);
        chk("R7 set alias read ones", r_data, ONES);
        chk("R7 set alias read err", {63'b0, r_err}, 64'd1);
        access(1'b0, 10'h29, 8'hFF, '0);
        chk("R7 clear alias read ones", r_data, ONES);
        access(1'b0, 10'h03, 8'hFF, '0);
        chk("R7 alias read no change", r_data, m_alias[3]);
    endtask

    task automatic t_unmapped();
        int idx [5] = '{'h06, 'h07, 'h16, 'h1A, 'h3FD};
        foreach (idx[i]) begin
            access(1'b1, AW'(idx[i]), 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF);
            chk("R8 unmapped write err", {63'b0, r_err}, 64'd1);
        end
        access(1'b0, 10'h05, 8'hFF, '0);
        chk("R8 unmapped write ignored ctrl5", r_data, m_alias[5]);
        access(1'b0, 10'h08, 8'hFF, '0);
        chk("R8 unmapped write ignored cfg0", r_data, m_alias[6]);
        access(1'b0, 10'h07, 8'hFF, '0);
        chk("R8 unmapped read ones", r_data, ONES);
    endtask

    task automatic t_partial();
        access(1'b1, 10'h02, 8'h7F, 64'h0);
        chk("R9 partial write err", {63'b0, r_err}, 64'd1);
        access(1'b1, 10'h12, 8'hFE, ONES);
        access(1'b0, 10'h02, 8'hFF, '0);
        chk("R9 partial writes ignored", r_data, m_alias[2]);
        access(1'b0, 10'h02, 8'h0F, '0);
        chk("R9 partial read ones", r_data, ONES);
        chk("R9 partial read err", {63'b0, r_err}, 64'd1);
    endtask

    task automatic t_sweep();
        int bad_cnt = 0;
        for (int i = 0; i < 1024; i++) begin
            logic e;
            logic [DW-1:0] x = exp_read(i, e);
            access(1'b0, AW'(i), 8'hFF, '0);
            if (r_data !== x || r_err !== e || r_ack !== 1'b1) begin
                bad_cnt++;
                $display("FAIL R8 sweep idx %h: actual=%h/%b expected=%h/%b", i, r_data, r_err, x, e);
            end
        end
        chk("R8 full window sweep mismatches", 64'(bad_cnt), 64'd0);
    endtask

    task automatic t_mid_reset();
        logic e;
        do_reset();
        access(1'b0, 10'h100, 8'hFF, '0);
        chk("R1 status zero after reset", r_data, exp_read('h100, e));
        access(1'b0, 10'h09, 8'hFF, '0);
        chk("R1 cfg1 zero after reset", r_data, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (m_alias[k]) m_alias[k] = '0;
        foreach (m_plain[j]) m_plain[j] = '0;
        t_reset_state();
        t_direct();
        t_set_clear();
        t_plain();
        t_alias_read();
        t_unmapped();
        t_partial();
        t_sweep();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule